// File: doc/BRIEF.md
# Compare and Auto-Reload Timer

This block is a memory-mapped timer peripheral. It watches a free-running 64-bit tick value supplied from outside and drives one level-sensitive interrupt line. Software talks to it through 32-bit word accesses on a simple address/write-strobe port. Read data is combinational from the address.

The timer has two ways to decide when to raise the interrupt. In absolute mode, a 64-bit deadline is compared against the tick value. Software can write that deadline directly as two halves. It can also write it through a signed 32-bit "time remaining" view, which is relative to the current tick.

In self-rearming mode the deadline path is ignored. Instead, a hidden 64-bit target is loaded with the tick plus a reload distance. Each time the tick reaches that target, a sticky event flag is set and the target moves forward again. The flag stays set until software writes a zero to it.

Top module: `cmp_reload_timer`

## Requirements
- R1: After reset, the following read as zero and the interrupt output is low: frequency (0x10), deadline halves (0x20/0x24), control (0x2C), reload (0x48), rearm control (0x4C) and target halves (0x40/0x44).
- R2: Writes to control (0x2C) keep only bit 0 (enable) and bit 1 (mask). A read of control returns enable in bit 0, mask in bit 1, the live status in bit 2, and zero above.
- R3: With rearm mode off, status is 1 exactly when enable is 1 and the unsigned 64-bit tick is at or above the 64-bit deadline (low half 0x20, high half 0x24).
- R4: A read of 0x28 returns the low 32 bits of (deadline minus tick). A write to 0x28 sets the deadline to the tick plus the written word, sign-extended to 64 bits.
- R5: irq_o is a register that holds (status AND NOT mask) from the previous clock. It is low whenever enable was 0 on that clock.
- R6: With enable and rearm mode both on, the absolute deadline has no effect. When the tick is at or above the target, the sticky flag (bit 1 of 0x4C) sets and the target becomes tick plus reload. In this mode, status equals the flag.
- R7: The sticky flag clears only when a write to 0x4C has bit 1 equal to 0. Writing 1 there leaves it unchanged. Bit 0 of 0x4C is the rearm-mode enable, readable and writable, and bit 1 reads back the flag.
- R8: The target (read at 0x40 low, 0x44 high) is loaded with tick plus reload in two cases: enable goes 0→1 while rearm mode is on, or rearm mode goes 0→1 while enable is on. Turning rearm mode on while enable is off does not load it.
- R9: The capability word at 0x50 reads 1. The twelve identification words from 0xFD0 to 0xFFC, in ascending address order, read the bytes 04, 00, 00, 00, B7, B0, 0B, 00, 0D, F0, 05, B1.
- R10: Writes to read-only words (0x0, 0x4, 0x40, 0x44, 0x50, the identification words) and to unmapped or unaligned addresses change nothing. Reads of unmapped or unaligned addresses return 0.
- R11: Reads of 0x0 and 0x4 return the low and high halves of the tick input.
- R12: The frequency word at 0x10 stores and returns any 32-bit value and has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Free-running tick value |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps the tick across a 32-bit carry boundary around a deadline whose high half is nonzero. A design that compares only 32 bits, or uses a strict greater-than, flips status at the wrong step.

The relative view is driven with negative values and with a value that carries into the high half. Wrong sign extension or a truncated sum would show up as a bad deadline readback.

In rearm mode the bench checks the following:
- The interrupt stays low while an already-passed absolute deadline is present.
- The target moves only on the two rearm events, across several reload distances, including one that carries.
- Writing 1 to the sticky flag does not clear it.

A design that cleared the flag on that write, or rearmed while disabled, would read back a wrong flag or target.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 64;
    localparam int DATA_W = 32;

    // word indices (byte offset / 4)
    localparam int W_CNT_LO   = 'h000;
    localparam int W_CNT_HI   = 'h001;
    localparam int W_FREQ     = 'h004;
    localparam int W_DL_LO    = 'h008;
    localparam int W_DL_HI    = 'h009;
    localparam int W_REL      = 'h00A;
    localparam int W_CTL      = 'h00B;
    localparam int W_TGT_LO   = 'h010;
    localparam int W_TGT_HI   = 'h011;
    localparam int W_RELOAD   = 'h012;
    localparam int W_RCTL     = 'h013;
    localparam int W_CAP      = 'h014;
    localparam int W_ID_FIRST = 'h3F4;
    localparam int W_ID_LAST  = 'h3FF;

    typedef struct packed {
        logic [DATA_W-1:0] freq;
        logic [CNT_W-1:0]  deadline;
        logic [DATA_W-1:0] reload;
        logic              en;
        logic              mask;
        logic              rearm_on;
    } tmr_cfg_t;

    typedef struct packed {
        logic rearm;
        logic flag_clr;
    } tmr_evt_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'hB7;
            4'd5:    return 8'hB0;
            4'd6:    return 8'h0B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    output tmr_cfg_t          cfg,
    output tmr_evt_t          evt
);

    logic [CNT_W-1:0] rel_sum;
    assign rel_sum = cnt_i + {{(CNT_W-DATA_W){wdata[DATA_W-1]}}, wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (word)
                WORD_W'(W_FREQ):   cfg.freq <= wdata;
                WORD_W'(W_DL_LO):  cfg.deadline[DATA_W-1:0] <= wdata;
                WORD_W'(W_DL_HI):  cfg.deadline[CNT_W-1:DATA_W] <= wdata;
                WORD_W'(W_REL):    cfg.deadline <= rel_sum;
                WORD_W'(W_CTL): begin
                    cfg.en   <= wdata[0];
                    cfg.mask <= wdata[1];
                end
                WORD_W'(W_RELOAD): cfg.reload <= wdata;
                WORD_W'(W_RCTL):   cfg.rearm_on <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        evt = '0;
        if (wr_en) begin
            if (word == WORD_W'(W_CTL) && cfg.rearm_on && !cfg.en && wdata[0])
                evt.rearm = 1'b1;
            if (word == WORD_W'(W_RCTL)) begin
                if (cfg.en && !cfg.rearm_on && wdata[0])
                    evt.rearm = 1'b1;
                if (!wdata[1])
                    evt.flag_clr = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_engine.sv
module tmr_engine
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  tmr_cfg_t         cfg,
    input  tmr_evt_t         evt,
    output logic [CNT_W-1:0] target,
    output logic             flag,
    output logic             status,
    output logic             irq
);

    logic [CNT_W-1:0] next_tgt;
    logic             fire;
    logic             dl_hit;

    assign next_tgt = cnt_i + {{(CNT_W-DATA_W){1'b0}}, cfg.reload};
    assign dl_hit   = (cnt_i >= cfg.deadline);
    assign fire     = cfg.en && cfg.rearm_on && !evt.rearm && (cnt_i >= target);
    assign status   = cfg.en && (cfg.rearm_on ? flag : dl_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
            flag   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (evt.rearm || fire)
                target <= next_tgt;
            if (fire)
                flag <= 1'b1;
            else if (evt.flag_clr)
                flag <= 1'b0;
            irq <= status && !cfg.mask;
        end
    end

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              hit,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  cnt_i,
    input  tmr_cfg_t          cfg,
    input  logic [CNT_W-1:0]  target,
    input  logic              flag,
    input  logic              status,
    output logic [DATA_W-1:0] rdata
);

    logic [CNT_W-1:0]  remain;
    logic [WORD_W-1:0] id_off;

    assign remain = cfg.deadline - cnt_i;
    assign id_off = word - WORD_W'(W_ID_FIRST);

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (word)
                WORD_W'(W_CNT_LO): rdata = cnt_i[DATA_W-1:0];
                WORD_W'(W_CNT_HI): rdata = cnt_i[CNT_W-1:DATA_W];
                WORD_W'(W_FREQ):   rdata = cfg.freq;
                WORD_W'(W_DL_LO):  rdata = cfg.deadline[DATA_W-1:0];
                WORD_W'(W_DL_HI):  rdata = cfg.deadline[CNT_W-1:DATA_W];
                WORD_W'(W_REL):    rdata = remain[DATA_W-1:0];
                WORD_W'(W_CTL):    rdata = {{(DATA_W-3){1'b0}}, status, cfg.mask, cfg.en};
                WORD_W'(W_TGT_LO): rdata = target[DATA_W-1:0];
                WORD_W'(W_TGT_HI): rdata = target[CNT_W-1:DATA_W];
                WORD_W'(W_RELOAD): rdata = cfg.reload;
                WORD_W'(W_RCTL):   rdata = {{(DATA_W-2){1'b0}}, flag, cfg.rearm_on};
                WORD_W'(W_CAP):    rdata = DATA_W'(1);
                default: begin
                    if (word >= WORD_W'(W_ID_FIRST) && word <= WORD_W'(W_ID_LAST))
                        rdata = {{(DATA_W-8){1'b0}}, id_byte(id_off[3:0])};
                end
            endcase
        end
    end

endmodule

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       cnt_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    tmr_cfg_t          cfg;
    tmr_evt_t          evt;
    logic [CNT_W-1:0]  ai_target;
    logic              ai_flag;
    logic              status;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    tmr_regfile #(.WORD_W(WORD_W)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && aligned),
        .word  (word),
        .wdata (bus_wdata),
        .cnt_i (cnt_i),
        .cfg   (cfg),
        .evt   (evt)
    );

    tmr_engine eng_i (
        .clk    (clk),
        .rst    (rst),
        .cnt_i  (cnt_i),
        .cfg    (cfg),
        .evt    (evt),
        .target (ai_target),
        .flag   (ai_flag),
        .status (status),
        .irq    (irq_o)
    );

    tmr_rdmux #(.WORD_W(WORD_W)) rd_i (
        .hit    (aligned),
        .word   (word),
        .cnt_i  (cnt_i),
        .cfg    (cfg),
        .target (ai_target),
        .flag   (ai_flag),
        .status (status),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_i,
    input logic             irq_o,
    input tmr_cfg_t         cfg,
    input tmr_evt_t         evt,
    input logic [CNT_W-1:0] target,
    input logic             flag
);

    // R3
    dl_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg.en && !cfg.rearm_on && !cfg.mask && (cnt_i >= cfg.deadline)) |-> irq_o);

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg.en) |-> !irq_o);

    // R5
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg.mask) |-> !irq_o);

    // R6
    dl_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg.rearm_on) && !$past(flag)) |-> !irq_o);

    // R6
    fire_sets_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg.en && cfg.rearm_on && !evt.rearm && (cnt_i >= target)) |-> flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag) && !$past(evt.flag_clr)) |-> flag);

    // R8
    rearm_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(evt.rearm) |-> (target == $past(cnt_i) + {32'b0, $past(cfg.reload)}));

endmodule

bind cmp_reload_timer tmr_checker chk_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (cnt_i),
    .irq_o  (irq_o),
    .cfg    (cfg),
    .evt    (evt),
    .target (ai_target),
    .flag   (ai_flag)
);

// File: tb/cmp_reload_timer_tb_top.sv
module cmp_reload_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] cnt;
    logic [11:0] addr;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cmp_reload_timer #(.ADDR_W(12)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cnt_i     (cnt),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_word(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_word(a, v);
        check(tag, {32'b0, v}, {32'b0, exp});
    endtask

    logic [7:0] id_tab [12];
    logic [63:0] base;
    logic [63:0] exp_dl;
    logic [63:0] exp_tgt;
    logic        st;

    initial begin
        id_tab = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hB7, 8'hB0,
                   8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        rst = 1'b1; wr = 1'b0; addr = '0; wdata = '0; cnt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 freq", 12'h010, 0);
        rd_check("R1 dl lo", 12'h020, 0);
        rd_check("R1 dl hi", 12'h024, 0);
        rd_check("R1 ctl", 12'h02C, 0);
        rd_check("R1 tgt lo", 12'h040, 0);
        rd_check("R1 tgt hi", 12'h044, 0);
        rd_check("R1 reload", 12'h048, 0);
        rd_check("R1 rctl", 12'h04C, 0);
        check("R1 irq", {63'b0, irq}, 0);

        // R11 tick readback
        cnt = 64'h1234_5678_9ABC_DEF0;
        rd_check("R11 lo", 12'h000, 32'h9ABC_DEF0);
        rd_check("R11 hi", 12'h004, 32'h1234_5678);

        // R10 read-only and unmapped
        wr_word(12'h000, 32'h1111_1111);
        rd_check("R10 ro tick", 12'h000, 32'h9ABC_DEF0);
        wr_word(12'h040, 32'h5);
        rd_check("R10 ro tgt", 12'h040, 0);
        wr_word(12'h050, 32'h0);
        rd_check("R10 ro cap", 12'h050, 1);
        wr_word(12'hFE0, 32'hFF);
        rd_check("R10 ro id", 12'hFE0, 32'hB7);
        rd_check("R10 unmapped", 12'h100, 0);
        wr_word(12'h021, 32'hDEAD_BEEF);
        rd_check("R10 unaligned wr", 12'h020, 0);
        rd_check("R10 unaligned rd", 12'h012, 0);

        // R12 frequency
        wr_word(12'h010, 32'hCAFE_0001);
        rd_check("R12 freq", 12'h010, 32'hCAFE_0001);

        // R9 capability and identification sweep
        rd_check("R9 cap", 12'h050, 1);
        for (int i = 0; i < 12; i++)
            rd_check($sformatf("R9 id %0d", i), 12'hFD0 + 12'(4*i), {24'b0, id_tab[i]});

        // R3 sweep around a 32-bit carry boundary
        base = 64'h1_0000_0000;
        wr_word(12'h020, 32'h0);
        wr_word(12'h024, 32'h1);
        wr_word(12'h02C, 32'h1);
        for (int d = -4; d <= 4; d++) begin
            cnt = base + 64'(d);
            st = (d >= 0);
            @(negedge clk);
            rd_check($sformatf("R3 ctl d=%0d", d), 12'h02C, {29'b0, st, 1'b0, 1'b1});
            check($sformatf("R5 irq d=%0d", d), {63'b0, irq}, {63'b0, st});
        end

        // R2 write masking, R5 masking and latency
        wr_word(12'h02C, 32'hFFFF_FFFF);
        rd_check("R2 ctl ff", 12'h02C, 32'h7);
        @(negedge clk);
        check("R5 masked", {63'b0, irq}, 0);
        wr_word(12'h02C, 32'h0);
        rd_check("R2 ctl off", 12'h02C, 32'h0);
        wr_word(12'h02C, 32'h1);
        check("R5 latency before", {63'b0, irq}, 0);
        @(negedge clk);
        check("R5 latency after", {63'b0, irq}, 1);

        // R4 relative view
        cnt = 64'd1000;
        wr_word(12'h028, 32'hFFFF_FFFB);
        rd_check("R4 neg dl lo", 12'h020, 32'd995);
        rd_check("R4 neg dl hi", 12'h024, 32'd0);
        rd_check("R4 neg rd", 12'h028, 32'hFFFF_FFFB);
        wr_word(12'h028, 32'd5);
        rd_check("R4 pos ctl", 12'h02C, 32'h1);
        cnt = 64'd1005;
        rd_check("R4 zero rd", 12'h028, 32'd0);
        rd_check("R4 reached ctl", 12'h02C, 32'h5);
        cnt = 64'hFFFF_FFFE;
        wr_word(12'h028, 32'd4);
        exp_dl = 64'h1_0000_0002;
        rd_check("R4 carry lo", 12'h020, exp_dl[31:0]);
        rd_check("R4 carry hi", 12'h024, exp_dl[63:32]);

        // R6 / R8 rearm mode
        wr_word(12'h02C, 32'h0);
        wr_word(12'h020, 32'h0);
        wr_word(12'h024, 32'h0);
        cnt = 64'd100;
        wr_word(12'h048, 32'd10);
        wr_word(12'h04C, 32'h1);
        rd_check("R8 no load while off", 12'h040, 32'd0);
        wr_word(12'h02C, 32'h1);
        rd_check("R8 enable load", 12'h040, 32'd110);
        rd_check("R6 dl ignored ctl", 12'h02C, 32'h1);
        @(negedge clk);
        check("R6 dl ignored irq", {63'b0, irq}, 0);
        cnt = 64'd109;
        @(negedge clk);
        rd_check("R6 before target", 12'h04C, 32'h1);
        cnt = 64'd110;
        @(negedge clk);
        rd_check("R6 flag set", 12'h04C, 32'h3);
        rd_check("R6 target moved", 12'h040, 32'd120);
        rd_check("R6 status mirrors", 12'h02C, 32'h5);
        @(negedge clk);
        check("R6 irq", {63'b0, irq}, 1);

        // R7 sticky flag
        wr_word(12'h04C, 32'h3);
        rd_check("R7 write one keeps", 12'h04C, 32'h3);
        wr_word(12'h04C, 32'h1);
        rd_check("R7 write zero clears", 12'h04C, 32'h1);
        @(negedge clk);
        check("R7 irq dropped", {63'b0, irq}, 0);

        // R8 reload sweep via rearm toggle
        for (int k = 0; k < 4; k++) begin
            logic [31:0] rl;
            rl  = (k == 3) ? 32'h20 : 32'(1 + 150 * k);
            cnt = (k == 3) ? 64'hFFFF_FFF0 : 64'(5000 + 17 * k);
            wr_word(12'h048, rl);
            wr_word(12'h04C, 32'h0);
            wr_word(12'h04C, 32'h1);
            exp_tgt = cnt + {32'b0, rl};
            rd_check($sformatf("R8 sweep lo %0d", k), 12'h040, exp_tgt[31:0]);
            rd_check($sformatf("R8 sweep hi %0d", k), 12'h044, exp_tgt[63:32]);
            rd_check($sformatf("R8 sweep flag %0d", k), 12'h04C, 32'h1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule